// File: doc/BRIEF.md
# Modem Line Status and Control Register Pair

This block keeps the two modem-signalling registers of a serial port. Four modem input lines (carrier detect, ring, data-set-ready and clear-to-send) are synchronised into the core clock. Their present levels are shown in the upper half of a status byte. The lower half holds sticky change flags. The host clears those flags by pulsing a read strobe when it takes the byte. A change-pending output goes high while any flag is set, so an interrupt reporter can tell that the modem state has moved.

A five-bit control register drives the DTR, RTS and two auxiliary outputs, and it holds a loopback switch. When loopback is on, the status half of the block ignores the external lines and uses the control outputs instead. This lets diagnostic software exercise the change flags without any cable attached. All line inputs are active-high: 1 means the signal is asserted.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the status byte, the control readback byte, the four control pins and change_pending are all 0.
- R2: Status bits 7, 6, 5 and 4 show the asserted state of CD, RI, DSR and CTS. An external line change appears there on the third rising clock edge after it is applied.
- R3: Status bit 3 (CD), bit 1 (DSR) and bit 0 (CTS) set in the same cycle that their line's status bit changes value, in either direction.
- R4: Status bit 2 sets only when RI goes from asserted to deasserted. A rising RI leaves bit 2 unchanged.
- R5: The change flags stay set until stat_rd is high at a rising edge. That edge clears them, after which status bits 3:0 read 0.
- R6: A line change that is detected at the same edge as a clearing read leaves its flag set after that edge.
- R7: Writing ctl_wr with ctl_wdata stores DTR in bit 0, RTS in bit 1, OUT1 in bit 2, OUT2 in bit 3 and loopback in bit 4. The value shows on ctl_byte, and bits 7:5 of ctl_byte are always 0. The pins dtr_out, rts_out, out1_out and out2_out follow bits 0 to 3.
- R8: With loopback set, CTS takes RTS, DSR takes DTR, RI takes OUT1 and CD takes OUT2. The status byte reflects a control write one edge after the write edge, and the external lines have no effect.
- R9: change_pending is high exactly when status bits 3:0 are not all zero.
- R10: Control value 0x08 deasserts DTR and RTS, 0x0A asserts RTS only and 0x09 asserts DTR only. OUT2 is asserted in all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_in | input | 1 | Carrier detect line, asynchronous, 1 = asserted |
| ri_in | input | 1 | Ring indicator line, asynchronous, 1 = asserted |
| dsr_in | input | 1 | Data set ready line, asynchronous, 1 = asserted |
| cts_in | input | 1 | Clear to send line, asynchronous, 1 = asserted |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write value: loopback, OUT2, OUT1, RTS, DTR (bit 4 down to 0) |
| stat_rd | input | 1 | Status read strobe; clears the change flags |
| stat_byte | output | 8 | Line states (7:4) and change flags (3:0) |
| ctl_byte | output | 8 | Control register readback, upper three bits zero |
| dtr_out | output | 1 | DTR output, 1 = asserted |
| rts_out | output | 1 | RTS output, 1 = asserted |
| out1_out | output | 1 | Auxiliary output 1 |
| out2_out | output | 1 | Auxiliary output 2 |
| change_pending | output | 1 | High while any change flag is set |

## Verification
The host's clearing read and a fresh line edge can land on the same clock edge, and the flag has to survive. The bench provokes this by changing an external line, waiting exactly two edges, and then holding stat_rd across the third edge, which is the one where the edge detector sees the change. It then expects the flag still set, and expects it to clear on a second read once the lines are quiet. An exhaustive sweep of every old/new pattern of the four lines, followed by a sweep of every loopback control value, covers the flag rules in both the external and the looped source.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int LINE_W = 4;
    localparam int CTL_W  = 5;
    localparam int BYTE_W = 8;

    localparam int CTL_DTR  = 0;
    localparam int CTL_RTS  = 1;
    localparam int CTL_OUT1 = 2;
    localparam int CTL_OUT2 = 3;
    localparam int CTL_LOOP = 4;

    typedef struct packed {
        logic cd;
        logic ri;
        logic dsr;
        logic cts;
    } mline_t;

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d.stg[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            s_d.stg[s] = s_q.stg[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stg[STAGES-1];

endmodule

// File: rtl/msr_ctl.sv
module msr_ctl
    import msr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    output logic [CTL_W-1:0] bits_o
);
    typedef struct packed {
        logic [CTL_W-1:0] bits;
    } ctl_st_t;

    ctl_st_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_i) c_d.bits = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign bits_o = c_q.bits;

    // R7: a write lands in the register at the next edge
    a_r7_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (bits_o == $past(wdata_i)));

    a_r7_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(bits_o));

endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import msr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  mline_t line_i,
    input  logic   rd_i,
    output mline_t line_o,
    output logic [LINE_W-1:0] delta_o
);
    typedef struct packed {
        mline_t            line;
        logic [LINE_W-1:0] delta;
    } dl_st_t;

    dl_st_t d_d, d_q;
    mline_t chg;
    logic [LINE_W-1:0] set_v;

    always_comb begin
        chg   = line_i ^ d_q.line;
        set_v = {chg.cd, (d_q.line.ri & ~line_i.ri), chg.dsr, chg.cts};
        d_d.line  = line_i;
        d_d.delta = (rd_i ? '0 : d_q.delta) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign line_o  = d_q.line;
    assign delta_o = d_q.delta;

    // R3: any change of CD, DSR or CTS leaves its flag set
    a_r3_cd_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o.cd != $past(line_o.cd)) |-> delta_o[3]);
    a_r3_dsr_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o.dsr != $past(line_o.dsr)) |-> delta_o[1]);
    a_r3_cts_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o.cts != $past(line_o.cts)) |-> delta_o[0]);

    // R4: ring flag rises only with a falling ring line
    a_r4_ring_trail: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_o[2]) |-> ($past(line_o.ri) && !line_o.ri));

    // R5: without a read, flags never drop
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> ((delta_o & $past(delta_o)) == $past(delta_o)));

    // R5: a read with quiet lines empties the flags
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (set_v == '0)) |=> (delta_o == '0));

endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cd_in,
    input  logic             ri_in,
    input  logic             dsr_in,
    input  logic             cts_in,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             stat_rd,
    output logic [BYTE_W-1:0] stat_byte,
    output logic [BYTE_W-1:0] ctl_byte,
    output logic             dtr_out,
    output logic             rts_out,
    output logic             out1_out,
    output logic             out2_out,
    output logic             change_pending
);
    localparam int PAD_W = BYTE_W - CTL_W;

    logic [LINE_W-1:0] ext_sync;
    logic [CTL_W-1:0]  ctl_q;
    mline_t            ext_line, loop_line, src_line, cur_line;
    logic [LINE_W-1:0] delta_q;

    msr_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cd_in, ri_in, dsr_in, cts_in}),
        .sync_o  (ext_sync)
    );

    msr_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctl_wr),
        .wdata_i (ctl_wdata),
        .bits_o  (ctl_q)
    );

    always_comb begin
        ext_line      = mline_t'(ext_sync);
        loop_line.cd  = ctl_q[CTL_OUT2];
        loop_line.ri  = ctl_q[CTL_OUT1];
        loop_line.dsr = ctl_q[CTL_DTR];
        loop_line.cts = ctl_q[CTL_RTS];
        src_line      = ctl_q[CTL_LOOP] ? loop_line : ext_line;
    end

    msr_delta u_delta (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (src_line),
        .rd_i    (stat_rd),
        .line_o  (cur_line),
        .delta_o (delta_q)
    );

    assign stat_byte      = {cur_line, delta_q};
    assign ctl_byte       = {{PAD_W{1'b0}}, ctl_q};
    assign dtr_out        = ctl_q[CTL_DTR];
    assign rts_out        = ctl_q[CTL_RTS];
    assign out1_out       = ctl_q[CTL_OUT1];
    assign out2_out       = ctl_q[CTL_OUT2];
    assign change_pending = |delta_q;

    // R8: in loopback the status lines follow the control outputs one edge later
    a_r8_loop_route: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_byte[CTL_LOOP] |=> (stat_byte[7:4] ==
            {$past(out2_out), $past(out1_out), $past(dtr_out), $past(rts_out)}));

    // R6: an edge seen during a clearing read keeps its flag
    a_r6_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && ctl_byte[CTL_LOOP] && (src_line.cts != cur_line.cts)) |=> stat_byte[0]);

endmodule

// File: tb/sim_modem_status_unit.sv
module sim_modem_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cd_in = 0, ri_in = 0, dsr_in = 0, cts_in = 0;
    logic       ctl_wr = 0;
    logic [4:0] ctl_wdata = '0;
    logic       stat_rd = 0;
    logic [7:0] stat_byte, ctl_byte;
    logic       dtr_out, rts_out, out1_out, out2_out, change_pending;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    modem_status_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .cd_in(cd_in), .ri_in(ri_in), .dsr_in(dsr_in), .cts_in(cts_in),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stat_rd(stat_rd),
        .stat_byte(stat_byte), .ctl_byte(ctl_byte),
        .dtr_out(dtr_out), .rts_out(rts_out), .out1_out(out1_out), .out2_out(out2_out),
        .change_pending(change_pending)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ext(input logic [3:0] v);
        {cd_in, ri_in, dsr_in, cts_in} = v;
    endtask

    task automatic do_read();
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
    endtask

    task automatic write_ctl(input logic [4:0] v);
        ctl_wdata = v;
        ctl_wr = 1'b1;
        tick(1);
        ctl_wr = 1'b0;
    endtask

    function automatic logic [3:0] exp_flags(input logic [3:0] o, input logic [3:0] n);
        logic [3:0] d;
        d = o ^ n;
        return {d[3], o[2] & ~n[2], d[1], d[0]};
    endfunction

    initial begin
        int cyc;
        for (cyc = 0; cyc < 200000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [3:0] ef;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk(stat_byte, 8'h00, "R1 status after reset");
        chk(ctl_byte, 8'h00, "R1 control after reset");
        chk({4'h0, dtr_out, rts_out, out1_out, out2_out}, 8'h00, "R1 pins after reset");
        chk({7'h0, change_pending}, 8'h00, "R1 pending after reset");

        // R2 latency: visible at the third edge, not the second
        set_ext(4'b0001);
        tick(2);
        chk(stat_byte, 8'h00, "R2 not yet after two edges");
        tick(1);
        chk(stat_byte, 8'h11, "R2 CTS visible on third edge");
        do_read();
        set_ext(4'b0000);
        tick(4);
        do_read();

        // R3 R4 R5 R9 exhaustive sweep of old/new line patterns
        for (int o = 0; o < 16; o++) begin
            for (int n = 0; n < 16; n++) begin
                set_ext(o[3:0]);
                tick(4);
                do_read();
                chk(stat_byte, {o[3:0], 4'h0}, "R5 flags cleared by read");
                set_ext(n[3:0]);
                tick(4);
                ef = exp_flags(o[3:0], n[3:0]);
                chk(stat_byte, {n[3:0], ef}, "R3 R4 flags after change");
                chk({7'h0, change_pending}, {7'h0, |ef}, "R9 pending follows flags");
                tick(3);
                chk(stat_byte, {n[3:0], ef}, "R5 flags sticky without read");
            end
        end

        // R4 ring rising alone sets nothing
        set_ext(4'b0000); tick(4); do_read();
        set_ext(4'b0100); tick(4);
        chk(stat_byte, 8'h40, "R4 rising ring leaves flag clear");
        set_ext(4'b0000); tick(4);
        chk(stat_byte, 8'h04, "R4 falling ring sets flag");
        do_read();

        // R6 edge coincides with clearing read
        set_ext(4'b1000);
        tick(2);
        stat_rd = 1'b1;
        tick(1);
        stat_rd = 1'b0;
        chk(stat_byte, 8'h88, "R6 edge during read keeps flag");
        do_read();
        chk(stat_byte, 8'h80, "R6 second read clears");
        set_ext(4'b0000); tick(4); do_read();

        // R7 control layout and reserved bits
        write_ctl(5'h0F);
        chk(ctl_byte, 8'h0F, "R7 control readback");
        chk({4'h0, out2_out, out1_out, rts_out, dtr_out}, 8'h0F, "R7 pin mapping");
        write_ctl(5'h05);
        chk({4'h0, out2_out, out1_out, rts_out, dtr_out}, 8'h05, "R7 DTR OUT1 only");
        write_ctl(5'h1F);
        chk(ctl_byte, 8'h1F, "R7 reserved bits zero");

        // R10 named values
        write_ctl(5'h08);
        chk({4'h0, out2_out, out1_out, rts_out, dtr_out}, 8'h08, "R10 value 08");
        write_ctl(5'h0A);
        chk({4'h0, out2_out, out1_out, rts_out, dtr_out}, 8'h0A, "R10 value 0A");
        write_ctl(5'h09);
        chk({4'h0, out2_out, out1_out, rts_out, dtr_out}, 8'h09, "R10 value 09");

        // R8 loopback sweep with external lines driven opposite
        write_ctl(5'h10);
        tick(2);
        do_read();
        for (int c = 0; c < 16; c++) begin
            logic [3:0] exp_line;
            exp_line = {c[3], c[2], c[0], c[1]};
            set_ext(~exp_line);
            ctl_wdata = {1'b1, c[3:0]};
            ctl_wr = 1'b1;
            @(posedge clk);
            @(negedge clk);
            ctl_wr = 1'b0;
            tick(1);
            chk({stat_byte[7:4], 4'h0}, {exp_line, 4'h0}, "R8 loopback routing");
            tick(4);
            chk({stat_byte[7:4], 4'h0}, {exp_line, 4'h0}, "R8 external ignored");
            do_read();
        end

        // R8 R3 loop flag then leave loopback
        write_ctl(5'h10);
        tick(2);
        do_read();
        write_ctl(5'h12);
        tick(1);
        chk(stat_byte, 8'h11, "R8 R3 loopback RTS sets CTS flag");
        set_ext(4'b0000);
        write_ctl(5'h00);
        tick(5);
        do_read();
        chk(stat_byte, 8'h00, "R8 external source restored");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule